// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block is the digital half of a reset supervisor. It watches a synchronized supply-OK comparator bit, a watchdog kick input that is active low, and the sensed levels of two bidirectional reset pins. It produces two open-drain drive enables that form a complementary pair. One enable pulls the active-high reset pin up. The other pulls the active-low reset pin down. Both enables always move together.

Every reset cause is stretched into a fixed-length timeout, counted in pulses of a timebase tick input. The causes are a low supply, an externally applied edge on either reset pin, and a watchdog expiry. The two pin inputs and the kick input first pass through a two-flop synchronizer and then an edge detector. Pin edges are ignored while the block drives the pins itself, and for a short guard window afterwards, so the block never retriggers on its own output. The block has no data stream, so every pin is a plain control level and there is no valid/ready handshake.

Top module: `rst_supervisor`

## Requirements
- R1: Whenever `supply_ok_i` is sampled low at a clock edge, both drive enables are 1 after that edge. They stay 1 for as long as the supply stays low, and no timeout is added on entry.
- R2: Count tick pulses at the clock edges where `supply_ok_i` is sampled high, starting from the first such edge after a low period. Both enables drop at the edge that samples the RST_TICKS-th such tick.
- R3: `rst_hi_drive_o` and `rst_lo_drive_o` hold equal values in every cycle. A value of 1 means "drive the pin to its active level".
- R4: A low-to-high change on `rst_hi_pin_i` asserts both enables on the third clock edge after the change. The reset then lasts RST_TICKS ticks.
- R5: A high-to-low change on `rst_lo_pin_n_i` asserts both enables on the third clock edge after the change. The reset then lasts RST_TICKS ticks.
- R6: Changes on the pins in the opposite direction have no effect. These are high-to-low on `rst_hi_pin_i` and low-to-high on `rst_lo_pin_n_i`.
- R7: Pin edges are ignored while the enables are 1 and for SYNC_STAGES+1 cycles after they drop. This covers the edges the block makes by driving the pins itself.
- R8: A high-to-low change on `wdi_n_i` clears the watchdog count. A low-to-high change on `wdi_n_i` does not clear it.
- R9: If WDOG_TICKS ticks pass with no clearing edge, both enables assert at the edge that samples the WDOG_TICKS-th tick. The reset then lasts RST_TICKS ticks.
- R10: The watchdog count is held at zero while the enables are 1. It starts counting from zero at the edge where they drop.
- R11: While `rst_n` is low, both enables are 1 and the reset timeout is fully loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle timebase pulse; all timeouts count these |
| supply_ok_i | input | 1 | Synchronized comparator bit: 1 when the supply is above the trip point |
| wdi_n_i | input | 1 | Watchdog kick; a falling edge clears the watchdog |
| rst_hi_pin_i | input | 1 | Sensed level of the active-high reset pin |
| rst_lo_pin_n_i | input | 1 | Sensed level of the active-low reset pin |
| rst_hi_drive_o | output | 1 | Enable that drives the active-high pin high |
| rst_lo_drive_o | output | 1 | Enable that drives the active-low pin low |

## Verification
The bench wires the pins as open-drain nets, so every reset the block drives shows up again on its own inputs.

- **Self-retrigger (R7).** A design without the guard window would hold reset forever or pulse it repeatedly.
- **Exact release tick.** The bench counts ticks up to release after a supply return and up to expiry after a watchdog restart. An off-by-one counter, or a watchdog that keeps counting during reset, would release or expire one tick early or late.
- **Wrong-direction edges (R6, R8).** The bench applies pin and kick edges in the direction that must be ignored. An edge detector with the wrong polarity would start a reset there or fail to clear the watchdog.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Every source that can start or hold a reset timeout.
  typedef struct packed {
    logic supply_low;
    logic pin_hi_edge;
    logic pin_lo_edge;
    logic wdog_expire;
  } rsv_cause_t;

  // Event causes that reload the timeout (the supply level is handled apart).
  function automatic logic restarts(input rsv_cause_t c);
    return c.pin_hi_edge | c.pin_lo_edge | c.wdog_expire;
  endfunction

endpackage

// File: rtl/rsv_edge_sync.sv
module rsv_edge_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0,
  parameter bit FALLING   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
      prev_q  <= RESET_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~chain_q[STAGES-1];
    end else begin : g_rise
      assign edge_o = ~prev_q & chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch #(
  parameter int RST_TICKS = 200,
  parameter int MASK_LEN  = 3,
  localparam int CW = $clog2(RST_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          supply_ok_i,
  input  logic          trig_i,
  output logic          rst_o,
  output logic          mask_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LOAD = CW'(RST_TICKS);

  logic [CW-1:0]       cnt_q, cnt_d;
  logic                rst_q;
  logic [MASK_LEN-1:0] hist_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!supply_ok_i || trig_i)
      cnt_d = LOAD;
    else if (tick_i && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LOAD;
      rst_q  <= 1'b1;
      hist_q <= '1;
    end else begin
      cnt_q  <= cnt_d;
      rst_q  <= (cnt_d != '0);
      hist_q <= {hist_q[MASK_LEN-2:0], rst_q};
    end
  end

  assign rst_o  = rst_q;
  assign mask_o = rst_q | (|hist_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog #(
  parameter int WDOG_TICKS = 1600,
  localparam int WW = $clog2(WDOG_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          kick_i,
  input  logic          hold_i,
  output logic          expire_o,
  output logic [WW-1:0] cnt_o
);
  localparam logic [WW-1:0] LAST = WW'(WDOG_TICKS - 1);

  logic [WW-1:0] cnt_q;

  assign expire_o = !hold_i && !kick_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (hold_i || kick_i || expire_o)
      cnt_q <= '0;
    else if (tick_i)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int RST_TICKS   = 200,
  parameter int WDOG_TICKS  = 1600,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(RST_TICKS + 1),
  localparam int WW = $clog2(WDOG_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic wdi_n_i,
  input  logic rst_hi_pin_i,
  input  logic rst_lo_pin_n_i,
  output logic rst_hi_drive_o,
  output logic rst_lo_drive_o
);
  import rsv_pkg::*;

  logic hi_rise, lo_fall, kick;
  logic guard, rst_active, expire;
  logic [CW-1:0] stretch_cnt;
  logic [WW-1:0] wdog_cnt;
  rsv_cause_t    cause;

  rsv_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b0)) u_hi_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rst_hi_pin_i), .edge_o(hi_rise));

  rsv_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1), .FALLING(1'b1)) u_lo_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rst_lo_pin_n_i), .edge_o(lo_fall));

  rsv_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1), .FALLING(1'b1)) u_kick_sync (
    .clk(clk), .rst_n(rst_n), .d_i(wdi_n_i), .edge_o(kick));

  always_comb begin
    cause.supply_low  = !supply_ok_i;
    cause.pin_hi_edge = hi_rise & ~guard;
    cause.pin_lo_edge = lo_fall & ~guard;
    cause.wdog_expire = expire;
  end

  rsv_stretch #(.RST_TICKS(RST_TICKS), .MASK_LEN(SYNC_STAGES + 1)) u_stretch (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .trig_i(restarts(cause)), .rst_o(rst_active), .mask_o(guard), .cnt_o(stretch_cnt));

  rsv_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick),
    .hold_i(rst_active), .expire_o(expire), .cnt_o(wdog_cnt));

  assign rst_hi_drive_o = rst_active;
  assign rst_lo_drive_o = rst_active;
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int RST_TICKS  = 200,
  parameter int WDOG_TICKS = 1600,
  localparam int CW = $clog2(RST_TICKS + 1),
  localparam int WW = $clog2(WDOG_TICKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          supply_ok_i,
  input logic          rst_hi_drive_o,
  input logic          rst_lo_drive_o,
  input logic [CW-1:0] stretch_cnt,
  input logic [WW-1:0] wdog_cnt
);
  // R1
  supply_low_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (rst_hi_drive_o && rst_lo_drive_o));

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hi_drive_o) |-> ($past(supply_ok_i) && $past(tick_i)));

  // R2
  stretch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stretch_cnt) <= RST_TICKS);

  // R10
  wdog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_lo_drive_o |=> (wdog_cnt == '0));

  // R9
  wdog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wdog_cnt) < WDOG_TICKS);
endmodule

bind rst_supervisor rsv_checker #(.RST_TICKS(RST_TICKS), .WDOG_TICKS(WDOG_TICKS)) u_rsv_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
  .rst_hi_drive_o(rst_hi_drive_o), .rst_lo_drive_o(rst_lo_drive_o),
  .stretch_cnt(stretch_cnt), .wdog_cnt(wdog_cnt));

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RT = 20;
  localparam int WT = 50;

  logic clk = 1'b0;
  logic rst_n, tick, supply_ok, wdi_n, ext_hi, ext_lo_n;
  logic drv_hi, drv_lo, hi_pin, lo_pin_n;
  logic kick_en;
  int   n_checks = 0, n_fails = 0, cyc = 0;
  string phase = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  // Open-drain pin nets: the block's own drive shows up on its inputs.
  assign hi_pin   = drv_hi | ext_hi;
  assign lo_pin_n = ~drv_lo & ext_lo_n;

  rst_supervisor #(.RST_TICKS(RT), .WDOG_TICKS(WT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_ok_i(supply_ok),
    .wdi_n_i(wdi_n), .rst_hi_pin_i(hi_pin), .rst_lo_pin_n_i(lo_pin_n),
    .rst_hi_drive_o(drv_hi), .rst_lo_drive_o(drv_lo));

  // ---------------- reference model built from the requirements ----------------
  logic hs1, hs2, hp, ls1, ls2, lp, ks1, ks2, kp;
  int   m_left, m_wd;
  logic m_on;
  logic [2:0] m_recent;

  function automatic int next_left(int left, logic ok, logic restart, logic tk);
    if (!ok || restart) return RT;
    if (tk && left > 0) return left - 1;
    return left;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs1 <= 0; hs2 <= 0; hp <= 0;
      ls1 <= 1; ls2 <= 1; lp <= 1;
      ks1 <= 1; ks2 <= 1; kp <= 1;
      m_left <= RT; m_on <= 1; m_recent <= 3'b111; m_wd <= 0;
    end else begin
      logic guard_m, pin_ev, kick_ev, wd_fire;
      int   nl;
      guard_m = m_on | (|m_recent);
      pin_ev  = !guard_m && ((hs2 && !hp) || (!ls2 && lp));
      kick_ev = !ks2 && kp;
      wd_fire = !m_on && !kick_ev && tick && (m_wd == WT - 1);
      nl = next_left(m_left, supply_ok, pin_ev | wd_fire, tick);
      m_left <= nl;
      m_on   <= (nl != 0);
      m_recent <= {m_recent[1:0], m_on};
      if (m_on || kick_ev || wd_fire) m_wd <= 0;
      else if (tick) m_wd <= m_wd + 1;
      hs1 <= hi_pin;   hs2 <= hs1; hp <= hs2;
      ls1 <= lo_pin_n; ls2 <= ls1; lp <= ls2;
      ks1 <= wdi_n;    ks2 <= ks1; kp <= ks2;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, plus the pair check (R3).
  always @(negedge clk) begin
    if (rst_n) begin
      chk(drv_hi, m_on, phase);
      chk(drv_lo, drv_hi, "R3");
    end
  end

  // Tick source and background kicker, driven away from the active edge.
  int kcnt = 0;
  always @(negedge clk) begin
    tick <= ($urandom_range(2) == 0);
    if (kick_en) begin
      kcnt <= (kcnt == 39) ? 0 : kcnt + 1;
      wdi_n <= (kcnt < 3) ? 1'b0 : 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  task automatic wait_level(input logic lvl, input int limit);
    int n = 0;
    while (drv_hi !== lvl && n < limit) begin @(negedge clk); n++; end
  endtask

  // Counts ticks sampled at posedges until the output reaches lvl.
  task automatic count_ticks_until(input logic lvl, output int n);
    n = 0;
    for (int g = 0; g < 5000; g++) begin
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
      if (drv_hi === lvl) break;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_n = 0; supply_ok = 0; wdi_n = 1; ext_hi = 0; ext_lo_n = 1; kick_en = 0; tick = 0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(drv_hi, 1'b1, "R11 hi enable in reset");
    chk(drv_lo, 1'b1, "R11 lo enable in reset");
    rst_n = 1;

    // R1: supply held low keeps reset
    phase = "R1";
    repeat (60) @(negedge clk);
    chk(drv_hi, 1'b1, "R1 held while supply low");

    // R2: exact release tick count after supply returns
    phase = "R2";
    supply_ok = 1; kick_en = 1;
    count_ticks_until(1'b0, n);
    chk_int(n, RT, "R2 ticks until release");

    // R7: self-driven pin edges do not retrigger
    phase = "R7";
    repeat (30) @(negedge clk);
    chk(drv_hi, 1'b0, "R7 no self retrigger");

    // R4: rising edge on the active-high pin
    phase = "R4";
    ext_hi = 1;
    @(negedge clk); chk(drv_hi, 1'b0, "R4 latency edge1");
    @(negedge clk); chk(drv_hi, 1'b0, "R4 latency edge2");
    @(negedge clk); chk(drv_hi, 1'b1, "R4 asserted edge3");
    ext_hi = 0;
    count_ticks_until(1'b0, n);
    chk_int(n, RT, "R4 timeout length");
    repeat (10) @(negedge clk);

    // R5: falling edge on the active-low pin
    phase = "R5";
    ext_lo_n = 0;
    @(negedge clk); chk(drv_lo, 1'b0, "R5 latency edge1");
    @(negedge clk); chk(drv_lo, 1'b0, "R5 latency edge2");
    @(negedge clk); chk(drv_lo, 1'b1, "R5 asserted edge3");
    // R7: the pins are held in the active direction externally during reset
    ext_hi = 1;
    count_ticks_until(1'b0, n);
    chk_int(n, RT, "R5 timeout length");
    repeat (10) @(negedge clk);
    chk(drv_hi, 1'b0, "R7 edges during reset ignored");

    // R6: opposite-direction edges
    phase = "R6";
    ext_hi = 0; ext_lo_n = 1;
    repeat (12) @(negedge clk);
    chk(drv_hi, 1'b0, "R6 opposite edges ignored");

    // R8: regular kicks prevent expiry
    phase = "R8";
    repeat (1500) @(negedge clk);
    chk(drv_hi, 1'b0, "R8 kicks keep watchdog clear");
    // R8: a rising kick edge alone does not clear
    kick_en = 0; wdi_n = 0;
    repeat (5) @(negedge clk);
    wdi_n = 1;
    wait_level(1'b1, 2000);
    chk(drv_hi, 1'b1, "R8 expiry despite rising edge");

    // R9 and R10: expiry exactly WT ticks after release
    phase = "R10";
    wait_level(1'b0, 2000);
    count_ticks_until(1'b1, n);
    chk_int(n, WT, "R10 count from zero after release");
    phase = "R9";
    count_ticks_until(1'b0, n);
    chk_int(n, RT, "R9 watchdog reset length");
    count_ticks_until(1'b1, n);
    chk_int(n, WT, "R9 watchdog period");

    // R1: drop during operation asserts at once
    phase = "R1";
    kick_en = 1;
    wait_level(1'b0, 2000);
    repeat (20) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    chk(drv_hi, 1'b1, "R1 immediate entry");
    supply_ok = 1;
    phase = "R2";
    count_ticks_until(1'b0, n);
    chk_int(n, RT, "R2 release after short dip");

    // Random mix, compared against the model every cycle
    phase = "R4/R5/R9 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(199) == 0) supply_ok = ~supply_ok;
      if ($urandom_range(99) == 0)  ext_hi = ~ext_hi;
      if ($urandom_range(99) == 0)  ext_lo_n = ~ext_lo_n;
      if ($urandom_range(499) == 0) kick_en = ~kick_en;
      if (!kick_en && $urandom_range(49) == 0) wdi_n = ~wdi_n;
    end
    supply_ok = 1;
    repeat (20) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule